// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter

This block looks at a table of interrupt sources and picks, for every CPU at once, the most urgent source that is both enabled and pending for that CPU. The enable, pending and priority state lives elsewhere and arrives here as flat vectors. Sources with low IDs carry a separate priority for each CPU. Higher IDs share a single priority across all CPUs. Each CPU also provides its priority mask, the priority of the interrupt it is currently running, and the enable of its own interface. One distributor enable is common to all CPUs.

For each CPU the block returns the ID of the winning pending source and a request line. The ID is shown only when the winner's priority passes that CPU's mask. The request is raised only when that winner would also pre-empt the running interrupt. A reserved ID of 1023 means "nothing to report". The search is a balanced tree of pairwise comparisons. A parameter selects whether the per-CPU results are registered (the default) or left combinational.

Top module: `prio_arbiter`

## Requirements
- R1: A source is a candidate for a CPU only when both its enable bit and its pending bit for that CPU are set; enable alone or pending alone never makes it the reported ID.
- R2: A numerically lower priority value is more urgent; among candidates with equal priority the lowest source ID wins.
- R3: When a CPU has no candidate at all, its pending ID is 1023 and its request is low.
- R4: The pending ID shows the winner when the winner's priority is less than or equal to the CPU's mask, and 1023 otherwise (for example, a priority of 0x30 passes a mask of 0x30, and 0x31 does not).
- R5: The request is high only when a winner passes the mask and its priority is strictly less than the CPU's 9-bit running priority. A running priority equal to the winner's gives no request, and a running priority of 0 never gives one.
- R6: When the distributor enable is low, or the CPU's interface enable is low, that CPU's request is low and its pending ID is 1023.
- R7: Sources with IDs below BANKED_SRC (default 32) take their priority from the requesting CPU's own bank. Higher IDs take their priority from the shared table.
- R8: With REG_OUT=1 the outputs change on the first rising clock edge after an input change. While reset is asserted, the pending IDs are 1023 and the requests are low.
- R9: With the idle settings defined in the package (mask 0xF0, running priority 0x100), a candidate of priority 0xF0 is reported and requested, and one of priority 0xF1 is neither.
- R10: The enable and pending bits of a source for one CPU have no effect on the outputs of any other CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| dist_en | input | 1 | Distributor enable, common to all CPUs |
| cpu_if_en | input | NUM_CPU | Interface enable per CPU |
| src_enable | input | NUM_CPU*NUM_SRC | Enable bit; the bit at cpu*NUM_SRC+id is source id for that CPU |
| src_pending | input | NUM_CPU*NUM_SRC | Pending bit, same layout as src_enable |
| banked_prio | input | NUM_CPU*BANKED_SRC*8 | Per-CPU priorities of the low IDs; byte at (cpu*BANKED_SRC+id)*8 |
| shared_prio | input | (NUM_SRC-BANKED_SRC)*8 | Shared priorities; byte at (id-BANKED_SRC)*8 |
| prio_mask | input | NUM_CPU*8 | Priority mask per CPU |
| run_prio | input | NUM_CPU*9 | Running priority per CPU; 0x100 means idle |
| pend_id | output | NUM_CPU*10 | Winning pending ID per CPU, 1023 when none |
| irq_req | output | NUM_CPU | Interrupt request per CPU |

## Verification
The checker examines the gating by the two enables, the 1023 result when no candidate exists, the range of every reported ID, the link between the request and a reported ID, and the absence of a request at running priority 0. Its properties do this on every cycle and for each CPU. It cannot work out which source should have won. Only the bench's scenarios can show that: the lower priority value winning, ties going to the lower ID, the mask boundary at equality, strict pre-emption against the running priority, the choice between a banked and a shared priority, and the one-cycle latency of the registered outputs.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

   localparam int PRIO_W = 8;
   localparam int RUN_W  = PRIO_W + 1;
   localparam int ID_W   = 10;

   localparam logic [ID_W-1:0]   NONE_ID    = 10'd1023;
   localparam logic [RUN_W-1:0]  IDLE_RUN   = 9'h100;
   localparam logic [PRIO_W-1:0] MASK_RESET = 8'hF0;

   typedef struct packed {
      logic              vld;
      logic [PRIO_W-1:0] prio;
      logic [ID_W-1:0]   id;
   } cand_t;

   // Left operand always carries the lower IDs, so ties keep it.
   function automatic cand_t pick_better(input cand_t lo, input cand_t hi);
      if (lo.vld && (!hi.vld || (lo.prio <= hi.prio)))
         return lo;
      return hi;
   endfunction

endpackage

// File: rtl/prio_leaf_build.sv
module prio_leaf_build
   import prio_arb_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int BANKED_SRC = 32,
   parameter int LEAVES     = 64
) (
   input  logic [NUM_SRC-1:0]                  en_row,
   input  logic [NUM_SRC-1:0]                  pend_row,
   input  logic [BANKED_SRC*PRIO_W-1:0]        own_prio,
   input  logic [(NUM_SRC-BANKED_SRC)*PRIO_W-1:0] shr_prio,
   output cand_t [LEAVES-1:0]                  leaves
);

   for (genvar s = 0; s < LEAVES; s++) begin : g_leaf
      if (s < BANKED_SRC) begin : g_banked
         assign leaves[s].vld  = en_row[s] & pend_row[s];
         assign leaves[s].prio = own_prio[s*PRIO_W +: PRIO_W];
         assign leaves[s].id   = ID_W'(s);
      end else if (s < NUM_SRC) begin : g_shared
         assign leaves[s].vld  = en_row[s] & pend_row[s];
         assign leaves[s].prio = shr_prio[(s-BANKED_SRC)*PRIO_W +: PRIO_W];
         assign leaves[s].id   = ID_W'(s);
      end else begin : g_pad
         assign leaves[s] = '{vld: 1'b0, prio: '1, id: NONE_ID};
      end
   end

endmodule

// File: rtl/prio_tree.sv
module prio_tree
   import prio_arb_pkg::*;
#(
   parameter int LEAVES = 64
) (
   input  cand_t [LEAVES-1:0] leaves,
   output cand_t              best
);

   localparam int LVLS = $clog2(LEAVES);

   if ((1 << LVLS) != LEAVES) begin : g_chk_pow2
      $error("prio_tree: LEAVES must be a power of two");
   end

   for (genvar l = 0; l <= LVLS; l++) begin : lv
      cand_t [(LEAVES>>l)-1:0] node;
      if (l == 0) begin : g_base
         assign node = leaves;
      end else begin : g_cmp
         for (genvar n = 0; n < (LEAVES >> l); n++) begin : g_node
            assign node[n] = pick_better(lv[l-1].node[2*n], lv[l-1].node[2*n+1]);
         end
      end
   end

   assign best = lv[LVLS].node[0];

endmodule

// File: rtl/prio_gate.sv
module prio_gate
   import prio_arb_pkg::*;
(
   input  cand_t             best,
   input  logic              dist_en,
   input  logic              if_en,
   input  logic [PRIO_W-1:0] mask,
   input  logic [RUN_W-1:0]  run,
   output logic [ID_W-1:0]   id,
   output logic              req
);

   logic passes;

   always_comb begin
      passes = dist_en && if_en && best.vld && (best.prio <= mask);
      id     = passes ? best.id : NONE_ID;
      req    = passes && ({1'b0, best.prio} < run);
   end

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
   import prio_arb_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int NUM_CPU    = 2,
   parameter int BANKED_SRC = 32,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   dist_en,
   input  logic [NUM_CPU-1:0]                     cpu_if_en,
   input  logic [NUM_CPU*NUM_SRC-1:0]             src_enable,
   input  logic [NUM_CPU*NUM_SRC-1:0]             src_pending,
   input  logic [NUM_CPU*BANKED_SRC*8-1:0]        banked_prio,
   input  logic [(NUM_SRC-BANKED_SRC)*8-1:0]      shared_prio,
   input  logic [NUM_CPU*8-1:0]                   prio_mask,
   input  logic [NUM_CPU*9-1:0]                   run_prio,
   output logic [NUM_CPU*10-1:0]                  pend_id,
   output logic [NUM_CPU-1:0]                     irq_req
);

   localparam int LEAVES = 1 << $clog2(NUM_SRC);

   if (NUM_SRC <= BANKED_SRC) begin : g_chk_src
      $error("prio_arbiter: NUM_SRC must exceed BANKED_SRC");
   end
   if (NUM_SRC > 1020) begin : g_chk_max
      $error("prio_arbiter: NUM_SRC must stay below the reserved IDs");
   end
   if (NUM_CPU < 1) begin : g_chk_cpu
      $error("prio_arbiter: NUM_CPU must be at least one");
   end

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      cand_t [LEAVES-1:0] leaves;
      cand_t              best;
      logic [ID_W-1:0]    id_d;
      logic               req_d;

      prio_leaf_build #(
         .NUM_SRC(NUM_SRC), .BANKED_SRC(BANKED_SRC), .LEAVES(LEAVES)
      ) u_leaf (
         .en_row  (src_enable[c*NUM_SRC +: NUM_SRC]),
         .pend_row(src_pending[c*NUM_SRC +: NUM_SRC]),
         .own_prio(banked_prio[c*BANKED_SRC*PRIO_W +: BANKED_SRC*PRIO_W]),
         .shr_prio(shared_prio),
         .leaves  (leaves)
      );

      prio_tree #(.LEAVES(LEAVES)) u_tree (
         .leaves(leaves),
         .best  (best)
      );

      prio_gate u_gate (
         .best   (best),
         .dist_en(dist_en),
         .if_en  (cpu_if_en[c]),
         .mask   (prio_mask[c*PRIO_W +: PRIO_W]),
         .run    (run_prio[c*RUN_W +: RUN_W]),
         .id     (id_d),
         .req    (req_d)
      );

      if (REG_OUT) begin : g_reg
         logic [ID_W-1:0] id_q;
         logic            req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               id_q  <= NONE_ID;
               req_q <= 1'b0;
            end else begin
               id_q  <= id_d;
               req_q <= req_d;
            end
         end
         assign pend_id[c*ID_W +: ID_W] = id_q;
         assign irq_req[c]              = req_q;
      end else begin : g_comb
         assign pend_id[c*ID_W +: ID_W] = id_d;
         assign irq_req[c]              = req_d;
      end
   end

endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
   parameter int NUM_SRC = 64,
   parameter int NUM_CPU = 2,
   parameter bit REG_OUT = 1'b1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         dist_en,
   input logic [NUM_CPU-1:0]           cpu_if_en,
   input logic [NUM_CPU*NUM_SRC-1:0]   src_enable,
   input logic [NUM_CPU*NUM_SRC-1:0]   src_pending,
   input logic [NUM_CPU*9-1:0]         run_prio,
   input logic [NUM_CPU*10-1:0]        pend_id,
   input logic [NUM_CPU-1:0]           irq_req
);

   logic warm;
   always_ff @(posedge clk) begin
      if (!rst_n) warm <= 1'b0;
      else        warm <= 1'b1;
   end

   if (REG_OUT) begin : g_reg_chk
      for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
         logic       any_cand;
         logic [9:0] idc;
         assign any_cand = |(src_enable[c*NUM_SRC +: NUM_SRC] & src_pending[c*NUM_SRC +: NUM_SRC]);
         assign idc      = pend_id[c*10 +: 10];

         assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && !($past(dist_en) && $past(cpu_if_en[c]))) |-> (!irq_req[c] && idc == 10'd1023));

         assert_no_cand_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && !$past(any_cand)) |-> (idc == 10'd1023 && !irq_req[c]));

         assert_run_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && $past(run_prio[c*9 +: 9]) == 9'd0) |-> !irq_req[c]);

         assert_req_has_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[c] |-> (idc != 10'd1023));

         assert_id_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (idc == 10'd1023) || (32'(idc) < NUM_SRC));
      end
   end

endmodule

bind prio_arbiter prio_arbiter_chk #(
   .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
   .src_enable(src_enable), .src_pending(src_pending), .run_prio(run_prio),
   .pend_id(pend_id), .irq_req(irq_req)
);

// File: tb/tb_prio_arbiter.sv
module tb_prio_arbiter;

   localparam int NS = 64;
   localparam int NC = 2;
   localparam int NB = 32;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    dist_en;
   logic [NC-1:0]           cpu_if_en;
   logic [NC*NS-1:0]        src_enable;
   logic [NC*NS-1:0]        src_pending;
   logic [NC*NB*8-1:0]      banked_prio;
   logic [(NS-NB)*8-1:0]    shared_prio;
   logic [NC*8-1:0]         prio_mask;
   logic [NC*9-1:0]         run_prio;
   logic [NC*10-1:0]        pend_id;
   logic [NC-1:0]           irq_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   prio_arbiter #(.NUM_SRC(NS), .NUM_CPU(NC), .BANKED_SRC(NB)) dut (
      .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_if_en(cpu_if_en),
      .src_enable(src_enable), .src_pending(src_pending),
      .banked_prio(banked_prio), .shared_prio(shared_prio),
      .prio_mask(prio_mask), .run_prio(run_prio),
      .pend_id(pend_id), .irq_req(irq_req)
   );

   // Two sources armed on CPU 0, then the expected winner and request.
   localparam int NV = 9;
   localparam int V_IDA [NV] = '{40,   40,   40,   40,   40,   40,   5,    40,   50};
   localparam int V_PA  [NV] = '{8'h20,8'h10,8'h30,8'h31,8'h20,8'h20,8'h08,8'hF0,8'hF1};
   localparam int V_IDB [NV] = '{50,   50,   50,   50,   50,   50,   63,   50,   63};
   localparam int V_PB  [NV] = '{8'h10,8'h10,8'h40,8'h40,8'h40,8'h40,8'h09,8'hF1,8'hF2};
   localparam int V_MSK [NV] = '{8'hF0,8'hF0,8'h30,8'h30,8'hF0,8'hF0,8'hF0,8'hF0,8'hF0};
   localparam int V_RUN [NV] = '{9'h100,9'h100,9'h100,9'h100,9'h20,9'h21,9'h100,9'h100,9'h100};
   localparam int V_EID [NV] = '{50,   40,   40,   1023, 40,   40,   5,    40,   1023};
   localparam int V_ERQ [NV] = '{1,    1,    1,    0,    0,    1,    1,    1,    0};
   localparam string V_TAG [NV] = '{"R2","R2","R4","R4","R5","R5","R7","R9","R9"};

   task automatic check(input string tag, input int cpu, input int exp_id, input bit exp_req);
      int got_id;
      bit got_req;
      got_id  = int'(pend_id[cpu*10 +: 10]);
      got_req = irq_req[cpu];
      n_tests++;
      if (got_id != exp_id || got_req != exp_req) begin
         n_fail++;
         $display("FAIL %s cpu%0d: id=%0d req=%0b, expected id=%0d req=%0b",
                  tag, cpu, got_id, got_req, exp_id, exp_req);
      end
   endtask

   task automatic clear_all();
      src_enable  = '0;
      src_pending = '0;
      banked_prio = '1;
      shared_prio = '1;
      dist_en     = 1'b1;
      cpu_if_en   = '1;
      for (int c = 0; c < NC; c++) begin
         prio_mask[c*8 +: 8] = 8'hF0;
         run_prio[c*9 +: 9]  = 9'h100;
      end
   endtask

   task automatic arm(input int cpu, input int id, input int p);
      src_enable[cpu*NS + id]  = 1'b1;
      src_pending[cpu*NS + id] = 1'b1;
      if (id < NB) banked_prio[(cpu*NB + id)*8 +: 8] = 8'(p);
      else         shared_prio[(id - NB)*8 +: 8]     = 8'(p);
   endtask

   task automatic settle();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: id=timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      clear_all();
      arm(0, 40, 8'h10);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state despite a ready candidate
      check("R8 reset", 0, 1023, 1'b0);
      check("R8 reset", 1, 1023, 1'b0);
      rst_n = 1'b1;
      clear_all();
      settle();
      check("R3 empty", 0, 1023, 1'b0);

      for (int v = 0; v < NV; v++) begin
         clear_all();
         arm(0, V_IDA[v], V_PA[v]);
         arm(0, V_IDB[v], V_PB[v]);
         prio_mask[7:0] = 8'(V_MSK[v]);
         run_prio[8:0]  = 9'(V_RUN[v]);
         settle();
         check(V_TAG[v], 0, V_EID[v], V_ERQ[v] != 0);
         check("R10 other cpu", 1, 1023, 1'b0);
      end

      // R1: enable alone, pending alone
      clear_all();
      src_enable[0*NS + 45]  = 1'b1;
      shared_prio[(45-NB)*8 +: 8] = 8'h10;
      src_pending[0*NS + 46] = 1'b1;
      shared_prio[(46-NB)*8 +: 8] = 8'h10;
      settle();
      check("R1 half armed", 0, 1023, 1'b0);

      // R6: distributor off, then one interface off
      clear_all();
      arm(0, 40, 8'h10);
      arm(1, 40, 8'h10);
      dist_en = 1'b0;
      settle();
      check("R6 dist off", 0, 1023, 1'b0);
      check("R6 dist off", 1, 1023, 1'b0);
      dist_en = 1'b1;
      cpu_if_en = 2'b10;
      settle();
      check("R6 if off", 0, 1023, 1'b0);
      check("R6 if on", 1, 40, 1'b1);

      // R7: banked priority differs per CPU against a shared source
      clear_all();
      arm(0, 5, 8'h10);
      arm(1, 5, 8'h80);
      arm(0, 40, 8'h40);
      arm(1, 40, 8'h40);
      settle();
      check("R7 banked cpu0", 0, 5, 1'b1);
      check("R7 banked cpu1", 1, 40, 1'b1);

      // R8: one-cycle latency of the registered outputs
      clear_all();
      settle();
      arm(0, 33, 8'h20);
      #1;
      check("R8 before edge", 0, 1023, 1'b0);
      settle();
      check("R8 after edge", 0, 33, 1'b1);

      // R2: lowest ID wins on a three-way tie across the tree halves
      clear_all();
      arm(0, 63, 8'h30);
      arm(0, 33, 8'h30);
      arm(0, 7, 8'h30);
      settle();
      check("R2 three-way tie", 0, 7, 1'b1);

      // R5: running priority zero never requests
      run_prio[8:0] = 9'h000;
      settle();
      check("R5 run zero", 0, 7, 1'b0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule